// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This block holds eight one-bit tokens shared between a left and a right port. Either port claims a token by writing a 0 to it, then reads the token back to see whether the claim was granted. A read returns 0 to the port that holds the token and 1 to the other port. Writing a 1 gives the token up. At any moment at most one port owns a given token, so two agents can guard a shared resource with it.

Each port has the following inputs:
- an active-low semaphore select,
- a memory enable that must be inactive for the access to count,
- a token index,
- write and read strobes,
- a one-bit write data line.

The unit is synchronous. State changes at the clock edge after a valid write. The read result appears on the port's read data output one cycle after a valid read strobe, and it holds there until the next valid read on that port.

Contention is settled inside the unit. If both ports claim the same free token in the same cycle, the left port wins. A claim that cannot be granted at once stays pending. The pending port receives the token in the cycle its owner releases it, with no second write needed.

Top module: `sem_unit`

## Requirements
- R1: After reset every token is free, both read data outputs are 1, and a read of any index returns 1 on both ports.
- R2: An access counts only when the port's select is 0 and its memory enable is 1. Any other combination leaves every token unchanged, and a read strobe under it leaves the read data output unchanged.
- R3: The 3-bit index picks one of eight tokens, and a write to one token leaves all the others unchanged.
- R4: A valid write of wdat=0 to a free token gives that token to the writing port. A valid read returns 0 to the owner and 1 to the other port one cycle after the strobe, and the value holds until the next valid read.
- R5: A valid write of wdat=1 by the owner frees the token when no request from the other port is pending.
- R6: When both ports write 0 to the same free token in the same cycle, the left port becomes owner and the right port's request stays pending.
- R7: A write of 0 by the non-owner is held as pending. The pending port becomes owner in the cycle after the owner writes 1. A write of 1 by the pending port withdraws its request.
- R8: Only the owner's write of 1 changes ownership of a held token. A repeated 0 from the owner, or any write by the other port, leaves the owner in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_n | input | 1 | Left semaphore select, active low |
| l_ce_n | input | 1 | Left memory enable, active low; must be 1 for a semaphore access |
| l_idx | input | 3 | Left token index |
| l_wr | input | 1 | Left write strobe |
| l_rd | input | 1 | Left read strobe |
| l_wdat | input | 1 | Left write data: 0 claims, 1 releases |
| l_rdat | output | 1 | Left read data: 0 = left owns the token |
| r_sem_n | input | 1 | Right semaphore select, active low |
| r_ce_n | input | 1 | Right memory enable, active low; must be 1 for a semaphore access |
| r_idx | input | 3 | Right token index |
| r_wr | input | 1 | Right write strobe |
| r_rd | input | 1 | Right read strobe |
| r_wdat | input | 1 | Right write data: 0 claims, 1 releases |
| r_rdat | output | 1 | Right read data: 0 = right owns the token |

## Verification
The assertions assume that a port never raises its write and read strobes in the same cycle. Under that assumption each port produces at most one claim or release per cycle, and a token that is free cannot also carry a pending request. The bench drives one strobe per port per cycle, changes inputs only on the falling edge, and waits a full cycle after each write before reading. It also applies invalid select and enable combinations so that the gating can be seen at the read outputs.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic {SIDE_L = 1'b0, SIDE_R = 1'b1} side_e;

   typedef struct packed {
      logic  owned;
      side_e owner;
      logic  pend_l;
      logic  pend_r;
   } sem_state_t;

   localparam sem_state_t SEM_FREE = '{owned: 1'b0, owner: SIDE_L, pend_l: 1'b0, pend_r: 1'b0};
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sem_n,
   input  logic               ce_n,
   input  logic [IDX_W-1:0]   idx,
   input  logic               wr,
   input  logic               rd,
   input  logic               wdat,
   output logic [NUM_SEM-1:0] req_o,
   output logic [NUM_SEM-1:0] rel_o,
   output logic               rd_valid_o
);
   logic sel_ok;
   assign sel_ok     = ~sem_n & ce_n;
   assign rd_valid_o = sel_ok & rd;

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_slot
      logic hit;
      assign hit      = sel_ok & wr & (idx == IDX_W'(i));
      assign req_o[i] = hit & ~wdat;
      assign rel_o[i] = hit & wdat;
   end

   AST_ONE_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_o | rel_o)); // R3
   AST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (sem_n || !ce_n) |-> ((req_o | rel_o) == '0 && !rd_valid_o)); // R2
endmodule

// File: rtl/sem_cell.sv
module sem_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic req_l,
   input  logic rel_l,
   input  logic req_r,
   input  logic rel_r,
   output logic held_l,
   output logic held_r
);
   sem_state_t st_q, st_d;
   logic own_l, own_r, pl, pr, freed;

   assign own_l = st_q.owned & (st_q.owner == SIDE_L);
   assign own_r = st_q.owned & (st_q.owner == SIDE_R);

   always_comb begin
      pl    = (st_q.pend_l | req_l) & ~rel_l & ~own_l;
      pr    = (st_q.pend_r | req_r) & ~rel_r & ~own_r;
      freed = ~st_q.owned | (own_l & rel_l) | (own_r & rel_r);
      st_d  = st_q;
      st_d.pend_l = pl;
      st_d.pend_r = pr;
      if (freed) begin
         if (pl) begin
            st_d.owned  = 1'b1;
            st_d.owner  = SIDE_L;
            st_d.pend_l = 1'b0;
         end else if (pr) begin
            st_d.owned  = 1'b1;
            st_d.owner  = SIDE_R;
            st_d.pend_r = 1'b0;
         end else begin
            st_d.owned  = 1'b0;
            st_d.owner  = SIDE_L;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SEM_FREE;
      else        st_q <= st_d;
   end

   assign held_l = own_l;
   assign held_r = own_r;

   AST_LEFT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!held_l && !held_r && req_l) |=> held_l); // R6
   AST_HANDOFF_L2R: assert property (@(posedge clk) disable iff (!rst_n)
      (held_l && rel_l && (st_q.pend_r || req_r)) |=> held_r); // R7
   AST_HANDOFF_R2L: assert property (@(posedge clk) disable iff (!rst_n)
      (held_r && rel_r && (st_q.pend_l || req_l)) |=> held_l); // R7
   AST_KEEP_L: assert property (@(posedge clk) disable iff (!rst_n)
      (held_l && !rel_l) |=> held_l); // R8
   AST_KEEP_R: assert property (@(posedge clk) disable iff (!rst_n)
      (held_r && !rel_r) |=> held_r); // R8
   AST_FREE_ON_REL: assert property (@(posedge clk) disable iff (!rst_n)
      (held_l && rel_l && !st_q.pend_r && !req_r) |=> (!held_l && !held_r)); // R5
endmodule

// File: rtl/sem_readback.sv
module sem_readback #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = $clog2(NUM_SEM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rd_valid,
   input  logic [IDX_W-1:0]   idx,
   input  logic [NUM_SEM-1:0] held,
   output logic               rdat
);
   always_ff @(posedge clk) begin
      if (!rst_n)        rdat <= 1'b1;
      else if (rd_valid) rdat <= ~held[idx];
   end

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |=> $stable(rdat)); // R4
endmodule

// File: rtl/sem_unit.sv
module sem_unit #(
   parameter int NUM_SEM = 8,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             l_sem_n,
   input  logic             l_ce_n,
   input  logic [IDX_W-1:0] l_idx,
   input  logic             l_wr,
   input  logic             l_rd,
   input  logic             l_wdat,
   output logic             l_rdat,
   input  logic             r_sem_n,
   input  logic             r_ce_n,
   input  logic [IDX_W-1:0] r_idx,
   input  logic             r_wr,
   input  logic             r_rd,
   input  logic             r_wdat,
   output logic             r_rdat
);
   localparam int SLOTS = 1 << IDX_W;

   if (NUM_SEM < 2) begin : g_chk_min
      $error("sem_unit: NUM_SEM must be at least 2");
   end
   if (NUM_SEM != SLOTS) begin : g_chk_pow
      $error("sem_unit: NUM_SEM must equal 2**IDX_W");
   end

   logic [NUM_SEM-1:0] req_l, rel_l, req_r, rel_r, held_l, held_r;
   logic rdv_l, rdv_r;

   sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_l (
      .clk(clk), .rst_n(rst_n), .sem_n(l_sem_n), .ce_n(l_ce_n), .idx(l_idx),
      .wr(l_wr), .rd(l_rd), .wdat(l_wdat),
      .req_o(req_l), .rel_o(rel_l), .rd_valid_o(rdv_l));

   sem_port_decode #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_dec_r (
      .clk(clk), .rst_n(rst_n), .sem_n(r_sem_n), .ce_n(r_ce_n), .idx(r_idx),
      .wr(r_wr), .rd(r_rd), .wdat(r_wdat),
      .req_o(req_r), .rel_o(rel_r), .rd_valid_o(rdv_r));

   for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
      sem_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .req_l(req_l[i]), .rel_l(rel_l[i]),
         .req_r(req_r[i]), .rel_r(rel_r[i]),
         .held_l(held_l[i]), .held_r(held_r[i]));
   end

   sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rb_l (
      .clk(clk), .rst_n(rst_n), .rd_valid(rdv_l), .idx(l_idx),
      .held(held_l), .rdat(l_rdat));

   sem_readback #(.NUM_SEM(NUM_SEM), .IDX_W(IDX_W)) u_rb_r (
      .clk(clk), .rst_n(rst_n), .rd_valid(rdv_r), .idx(r_idx),
      .held(held_r), .rdat(r_rdat));

   AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (held_l & held_r) == '0); // R8
endmodule

// File: tb/tb_sem_unit.sv
module tb_sem_unit;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic l_sem_n, l_ce_n, l_wr, l_rd, l_wdat, r_sem_n, r_ce_n, r_wr, r_rd, r_wdat;
   logic [2:0] l_idx, r_idx;
   logic l_rdat, r_rdat;
   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   sem_unit dut (
      .clk(clk), .rst_n(rst_n),
      .l_sem_n(l_sem_n), .l_ce_n(l_ce_n), .l_idx(l_idx), .l_wr(l_wr), .l_rd(l_rd),
      .l_wdat(l_wdat), .l_rdat(l_rdat),
      .r_sem_n(r_sem_n), .r_ce_n(r_ce_n), .r_idx(r_idx), .r_wr(r_wr), .r_rd(r_rd),
      .r_wdat(r_wdat), .r_rdat(r_rdat));

   task automatic check(input string tag, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic idle();
      l_sem_n = 1'b1; l_ce_n = 1'b1; l_wr = 1'b0; l_rd = 1'b0; l_wdat = 1'b0; l_idx = '0;
      r_sem_n = 1'b1; r_ce_n = 1'b1; r_wr = 1'b0; r_rd = 1'b0; r_wdat = 1'b0; r_idx = '0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      idle();
   endtask

   task automatic wr_l(input logic [2:0] i, input logic d);
      l_sem_n = 1'b0; l_wr = 1'b1; l_idx = i; l_wdat = d;
   endtask

   task automatic wr_r(input logic [2:0] i, input logic d);
      r_sem_n = 1'b0; r_wr = 1'b1; r_idx = i; r_wdat = d;
   endtask

   task automatic rd_both(input logic [2:0] i, input logic el, input logic er, input string tag);
      l_sem_n = 1'b0; l_rd = 1'b1; l_idx = i;
      r_sem_n = 1'b0; r_rd = 1'b1; r_idx = i;
      tick();
      check({tag, " left"}, l_rdat, el);
      check({tag, " right"}, r_rdat, er);
   endtask

   task automatic t_reset();
      check("R1 left rdat after reset", l_rdat, 1'b1);
      check("R1 right rdat after reset", r_rdat, 1'b1);
      for (int i = 0; i < 8; i++) rd_both(3'(i), 1'b1, 1'b1, "R1 free token");
   endtask

   task automatic t_grant();
      wr_l(3'd2, 1'b0); tick();
      rd_both(3'd2, 1'b0, 1'b1, "R4 left owns 2");
      rd_both(3'd3, 1'b1, 1'b1, "R3 token 3 untouched");
      wr_r(3'd6, 1'b0); tick();
      rd_both(3'd6, 1'b1, 1'b0, "R4 right owns 6");
      rd_both(3'd2, 1'b0, 1'b1, "R3 token 2 kept");
      wr_l(3'd2, 1'b1); tick();
      rd_both(3'd2, 1'b1, 1'b1, "R5 left release 2");
      wr_r(3'd6, 1'b1); tick();
      rd_both(3'd6, 1'b1, 1'b1, "R5 right release 6");
   endtask

   task automatic t_tie();
      wr_l(3'd5, 1'b0); wr_r(3'd5, 1'b0); tick();
      rd_both(3'd5, 1'b0, 1'b1, "R6 tie left wins");
      wr_l(3'd5, 1'b1); tick();
      rd_both(3'd5, 1'b1, 1'b0, "R7 pending right granted");
      wr_r(3'd5, 1'b1); tick();
      rd_both(3'd5, 1'b1, 1'b1, "R5 token 5 free");
   endtask

   task automatic t_cancel();
      wr_r(3'd1, 1'b0); tick();
      wr_l(3'd1, 1'b0); tick();
      rd_both(3'd1, 1'b1, 1'b0, "R7 left pending not owner");
      wr_l(3'd1, 1'b1); tick();
      wr_r(3'd1, 1'b1); tick();
      rd_both(3'd1, 1'b1, 1'b1, "R7 withdrawn request not granted");
   endtask

   task automatic t_no_steal();
      wr_l(3'd0, 1'b0); tick();
      wr_r(3'd0, 1'b1); tick();
      rd_both(3'd0, 1'b0, 1'b1, "R8 right release ignored");
      wr_l(3'd0, 1'b0); tick();
      rd_both(3'd0, 1'b0, 1'b1, "R8 repeat claim keeps owner");
      wr_l(3'd0, 1'b1); tick();
      rd_both(3'd0, 1'b1, 1'b1, "R5 token 0 free");
   endtask

   task automatic t_gating();
      wr_l(3'd4, 1'b0); l_ce_n = 1'b0; tick();
      rd_both(3'd4, 1'b1, 1'b1, "R2 write with enable active ignored");
      l_sem_n = 1'b1; l_wr = 1'b1; l_idx = 3'd4; l_wdat = 1'b0; tick();
      rd_both(3'd4, 1'b1, 1'b1, "R2 write without select ignored");
      wr_l(3'd7, 1'b0); tick();
      rd_both(3'd7, 1'b0, 1'b1, "R4 left owns 7");
      l_sem_n = 1'b1; l_rd = 1'b1; l_idx = 3'd4; tick();
      check("R2 read without select holds", l_rdat, 1'b0);
      l_sem_n = 1'b0; l_ce_n = 1'b0; l_rd = 1'b1; l_idx = 3'd4; tick();
      check("R2 read with enable active holds", l_rdat, 1'b0);
      tick();
      check("R4 rdat holds while idle", l_rdat, 1'b0);
      wr_l(3'd7, 1'b1); tick();
      rd_both(3'd7, 1'b1, 1'b1, "R5 token 7 free");
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_grant();
      t_tie();
      t_cancel();
      t_no_steal();
      t_gating();
      summary();
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
   end
endmodule